// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block is a synthesizable model of a small synchronous SRAM with a burst address counter, driven by one combined advance/load control. At each rising clock edge it decodes chip enable, advance/load, write enable, the per-byte write selects, clock enable and sleep. From these it picks one operation: deselect, read, dummy read, write, write abort, stall or sleep. Storage is a word array with byte-masked writes. The data bus is split into an input word, an output word and a drive enable, which a pad ring turns into a three-state bus.

A cycle with advance/load low starts a new operation at the external address. A cycle with advance/load high continues the previous operation at the next address of a four-beat burst. Read data occupies the bus in the cycle that ends at the second enabled edge after the address. Write data is captured at that same second enabled edge. Reads and writes can therefore alternate on consecutive cycles with no turnaround gap. A write followed at once by a read of the same word returns the new data.

Top module: `sbsram_ctl`

## Requirements
- R1: After synchronous reset, `dq_oe` is 0 whatever the level of `oe_n`, and no operation is in flight.
- R2: A cycle with `adv_ld_n`=0 and `ce_n`=1 is a deselect. Later cycles with `adv_ld_n`=1 stay deselected whatever `ce_n`, `we_n` and `bw_n` are: no array word changes and `dq_oe` stays 0.
- R3: A cycle with `ce_n`=0, `adv_ld_n`=0 and `we_n`=1, accepted at enabled edge k, drives the word at `adr` on `dq_o` with `dq_oe`=1 in the cycle between enabled edges k+1 and k+2, provided `oe_n`=0 and `sleep`=0 then.
- R4: A cycle with `ce_n`=0, `adv_ld_n`=0 and `we_n`=0, accepted at enabled edge k, writes `dq_i` as sampled at enabled edge k+2. Only the lanes i whose `bw_n[i]` was 0 at edge k are written, lane i being bits 8i+7..8i.
- R5: With `adv_ld_n`=1, the previous operation type repeats at the next burst address. The burst keeps the upper address bits and steps the two low bits as (start XOR beat count) by default, or (start + beat count) mod 4 when `LINEAR`=1. The sequence wraps after four beats.
- R6: A read whose data cycle has `oe_n`=1 is a dummy read: `dq_oe` stays 0, but the burst address still advances.
- R7: A write with all `bw_n` bits at 1 is a write abort: no word changes, but the burst address still advances on the following continue cycles.
- R8: With `cen_n`=1 the clock edge is ignored: no state changes, and `dq_oe`/`dq_o` keep their values.
- R9: With `sleep`=1, `dq_oe` is 0 regardless of every other input, and clock edges are ignored until `sleep` returns to 0.
- R10: `oe_n` acts combinationally on `dq_oe`, with no clock edge in between.
- R11: In the cycle in which write data is being taken, `dq_oe` is 0 even when `oe_n`=0, also for partial byte writes.
- R12: A read issued on the enabled cycle right after a write to the same address returns the newly merged word.
- R13: On continue cycles of a read burst, `we_n` and `bw_n` are ignored. On continue cycles of a write burst, `bw_n` is taken fresh on every beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Chip enable, active low, sampled on load cycles |
| adv_ld_n | input | 1 | 0 = load new address and operation, 1 = continue burst |
| we_n | input | 1 | Write enable, active low, sampled on load cycles |
| bw_n | input | LANES | Byte write selects, active low |
| adr | input | ADDR_W | External word address |
| cen_n | input | 1 | Clock enable, active low; 1 inserts a wait state |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep, active high; floats the bus and freezes state |
| dq_i | input | DATA_W | Data from the bus (write data) |
| dq_o | output | DATA_W | Data toward the bus (read data) |
| dq_oe | output | 1 | Bus drive enable for `dq_o` |

## Verification
A behavioural reference model keeps a two-slot queue of accepted operations and a word array, and both outputs are compared after every clock. The stimulus runs full-word write bursts that start at every low-address offset, which separates an interleaved sequence from a linear one and from a missing wrap. Read bursts follow, with dummy-read beats mixed in to show that a silent beat still advances the address. Write aborts and walking single-lane masks show that the lanes are independent. Alternating write/read pairs on one address expose a missing forward path. Stalls, sleep and `oe_n` toggles in the middle of the data cycle separate held state from merely blanked output, and a long random mix covers combinations of the controls.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

    // Width of the in-burst beat counter (four-beat bursts)
    localparam int BEAT_W = 2;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_e;

    // Active-low lane selects to active-high lane write enables
    function automatic logic [7:0] lane_en(input logic [7:0] sel_n);
        return ~sel_n;
    endfunction

endpackage

// File: rtl/sbsram_burst.sv
module sbsram_burst #(
    parameter int BEAT_W = 2,
    parameter bit LINEAR = 1'b0
) (
    input  logic [BEAT_W-1:0] base,
    input  logic [BEAT_W-1:0] step,
    output logic [BEAT_W-1:0] ofs
);

    generate
        if (LINEAR) begin : g_lin
            assign ofs = base + step;
        end else begin : g_xor
            assign ofs = base ^ step;
        end
    endgenerate

endmodule

// File: rtl/sbsram_cmd.sv
module sbsram_cmd
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter bit LINEAR = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              ce_n,
    input  logic              adv_ld_n,
    input  logic              we_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic [ADDR_W-1:0] adr,
    output op_e               op_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [LANES-1:0]  bw_n_o
);

    op_e               last_op;
    logic [ADDR_W-1:0] base_q;
    logic [BEAT_W-1:0] cnt_q;
    logic [BEAT_W-1:0] step;
    logic [BEAT_W-1:0] ofs;

    assign step   = cnt_q + BEAT_W'(1);
    assign bw_n_o = bw_n;

    sbsram_burst #(
        .BEAT_W (BEAT_W),
        .LINEAR (LINEAR)
    ) u_seq (
        .base (base_q[BEAT_W-1:0]),
        .step (step),
        .ofs  (ofs)
    );

    always_comb begin
        if (!adv_ld_n) begin
            addr_o = adr;
            if (ce_n)      op_o = OP_NONE;
            else if (we_n) op_o = OP_RD;
            else           op_o = OP_WR;
        end else begin
            addr_o = {base_q[ADDR_W-1:BEAT_W], ofs};
            op_o   = last_op;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_op <= OP_NONE;
            base_q  <= '0;
            cnt_q   <= '0;
        end else if (en) begin
            last_op <= op_o;
            if (!adv_ld_n) begin
                base_q <= adr;
                cnt_q  <= '0;
            end else begin
                cnt_q  <= step;
            end
        end
    end

    // R2: a deselect keeps continuation cycles idle
    p_desel_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (en && !adv_ld_n && ce_n) |=> (!adv_ld_n || op_o == OP_NONE));

    // R5: a continuation repeats the previously decoded operation type
    p_cont_type_r5: assert property (@(posedge clk) disable iff (rst)
        en |=> (!adv_ld_n || op_o == $past(op_o)));

endmodule

// File: rtl/sbsram_mem.sv
module sbsram_mem #(
    parameter int DATA_W = 32,
    parameter int LANES  = 4,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [LANES-1:0]  wbe,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int LANE_W = DATA_W / LANES;
    localparam int DEPTH  = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] fwd;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign merged[i*LANE_W +: LANE_W] = wbe[i] ? wdata[i*LANE_W +: LANE_W]
                                                   : cells[waddr][i*LANE_W +: LANE_W];
    end

    // Same-edge write and read of one word: hand over the merged word
    assign fwd = (we && waddr == raddr) ? merged : cells[raddr];

    always_ff @(posedge clk) begin
        if (en && we) cells[waddr] <= merged;
    end

    always_ff @(posedge clk) begin
        if (rst)            rdata <= '0;
        else if (en && re)  rdata <= fwd;
    end

    // R12: read right behind a write to the same word sees the new value
    p_fwd_r12: assert property (@(posedge clk) disable iff (rst)
        (en && we && re && waddr == raddr) |=> rdata == $past(merged));

endmodule

// File: rtl/sbsram_ctl.sv
module sbsram_ctl
    import sbsram_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = 4,
    parameter int ADDR_W = 6,
    parameter bit LINEAR = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              adv_ld_n,
    input  logic              we_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic [ADDR_W-1:0] adr,
    input  logic              cen_n,
    input  logic              oe_n,
    input  logic              sleep,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe
);

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  bw_n;
    } slot_t;

    logic  en;
    slot_t s0, p1, p2;

    assign en = !cen_n && !sleep;

    sbsram_cmd #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LINEAR (LINEAR)
    ) u_cmd (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .ce_n     (ce_n),
        .adv_ld_n (adv_ld_n),
        .we_n     (we_n),
        .bw_n     (bw_n),
        .adr      (adr),
        .op_o     (s0.op),
        .addr_o   (s0.addr),
        .bw_n_o   (s0.bw_n)
    );

    // Two enabled stages: address stage, then bus data stage
    always_ff @(posedge clk) begin
        if (rst) begin
            p1 <= '0;
            p2 <= '0;
        end else if (en) begin
            p1 <= s0;
            p2 <= p1;
        end
    end

    sbsram_mem #(
        .DATA_W (DATA_W),
        .LANES  (LANES),
        .ADDR_W (ADDR_W)
    ) u_mem (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .we    (p2.op == OP_WR),
        .waddr (p2.addr),
        .wbe   (~p2.bw_n),
        .wdata (dq_i),
        .re    (p1.op == OP_RD),
        .raddr (p1.addr),
        .rdata (dq_o)
    );

    // Output enable is not registered; write cycles never reach this term
    assign dq_oe = (p2.op == OP_RD) && !oe_n && !sleep;

    // R1: bus released right after reset
    p_hiz_after_rst_r1: assert property (@(posedge clk)
        $past(rst) |-> !dq_oe);

    // R8: a wait state freezes the pipeline
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cen_n)) |-> ($stable(p1) && $stable(p2)));

    // R9: sleep freezes the pipeline
    p_sleep_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(sleep)) |-> ($stable(p1) && $stable(p2)));

    // R11: the cycle that takes write data never drives the bus
    p_wr_mask_r11: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(en) && $past(p1.op) == OP_WR) |-> !dq_oe);

endmodule

// File: tb/tb_sbsram_ctl.sv
module tb_sbsram_ctl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1;
    logic        adv_ld_n = 1'b0;
    logic        we_n = 1'b1;
    logic [3:0]  bw_n = 4'hF;
    logic [5:0]  adr = '0;
    logic        cen_n = 1'b0;
    logic        oe_n = 1'b0;
    logic        sleep = 1'b0;
    logic [31:0] dq_i = '0;
    logic [31:0] dq_o;
    logic        dq_oe;

    always #5 clk = ~clk;

    sbsram_ctl dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .adv_ld_n(adv_ld_n), .we_n(we_n),
        .bw_n(bw_n), .adr(adr), .cen_n(cen_n), .oe_n(oe_n), .sleep(sleep),
        .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
    );

    typedef struct {
        int         t;   // 0 idle, 1 read, 2 write
        int         a;
        logic [3:0] bw;
    } mop_t;

    mop_t        q[$];
    logic [31:0] mem_m [64];
    bit          known [64];
    int          last_t, base, cnt;
    int          checks = 0, fails = 0;
    string       cur_req = "R1";

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        mop_t o, n, idle;
        idle.t = 0; idle.a = 0; idle.bw = 4'hF;
        if (rst) begin
            q.delete();
            q.push_back(idle);
            q.push_back(idle);
            last_t = 0; base = 0; cnt = 0;
            return;
        end
        if (cen_n || sleep) return;
        o = q.pop_front();
        if (o.t == 2) begin
            if (o.bw == 4'h0) begin
                mem_m[o.a] = dq_i;
                known[o.a] = 1'b1;
            end else if (known[o.a]) begin
                for (int i = 0; i < 4; i++)
                    if (!o.bw[i]) mem_m[o.a][i*8 +: 8] = dq_i[i*8 +: 8];
            end
        end
        if (!adv_ld_n) begin
            n.t = ce_n ? 0 : (we_n ? 1 : 2);
            base = int'(adr); cnt = 0; n.a = int'(adr);
        end else begin
            n.t = last_t;
            cnt = (cnt + 1) % 4;
            n.a = (base & ~3) | ((base ^ cnt) & 3);
        end
        n.bw = bw_n;
        last_t = n.t;
        q.push_back(n);
    endtask

    task automatic cycle_check();
        logic exp_oe;
        exp_oe = (q[0].t == 1) && !oe_n && !sleep;
        chk(dq_oe === exp_oe, cur_req, {31'b0, dq_oe}, {31'b0, exp_oe});
        if (exp_oe && known[q[0].a])
            chk(dq_o === mem_m[q[0].a], cur_req, dq_o, mem_m[q[0].a]);
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        cycle_check();
        dq_i = $urandom;
    endtask

    task automatic cmd(input logic c, input logic a, input logic w, input logic [3:0] b, input int ad);
        ce_n = c; adv_ld_n = a; we_n = w; bw_n = b; adr = ad[5:0];
        tick();
    endtask

    task automatic wr_load(input int ad, input logic [3:0] b); cmd(1'b0, 1'b0, 1'b0, b, ad); endtask
    task automatic rd_load(input int ad); cmd(1'b0, 1'b0, 1'b1, 4'hF, ad); endtask
    task automatic cont(input logic w, input logic [3:0] b); cmd(1'b0, 1'b1, w, b, 0); endtask
    task automatic desel(); cmd(1'b1, 1'b0, 1'b1, 4'hF, 0); endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        #(10 * 150000);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) known[i] = 1'b0;
        // R1: reset with output enable active
        cur_req = "R1";
        repeat (3) tick();
        rst = 1'b0;
        desel();
        chk(dq_oe === 1'b0, "R1", {31'b0, dq_oe}, 32'h0);

        // R4/R5: full-word write bursts starting at each low offset
        cur_req = "R5";
        for (int b = 0; b < 16; b++) begin
            wr_load(b * 4 + (b % 4), 4'h0);
            for (int k = 0; k < 3; k++) cont(1'b0, 4'h0);
        end
        desel(); desel();
        for (int b = 0; b < 16; b++) begin
            rd_load(b * 4 + ((b + 1) % 4));
            for (int k = 0; k < 3; k++) cont(1'b1, 4'hF);
        end
        desel(); desel();

        // R3: single reads
        cur_req = "R3";
        rd_load(5); desel(); desel(); rd_load(62); rd_load(1); desel(); desel();

        // R2: deselect, then continuation cycles that look like writes
        cur_req = "R2";
        desel();
        for (int k = 0; k < 4; k++) cont(1'b0, 4'h0);
        desel();
        rd_load(0); for (int k = 0; k < 3; k++) cont(1'b1, 4'hF);
        desel(); desel();

        // R6: dummy-read beats followed by visible beats
        cur_req = "R6";
        oe_n = 1'b1;
        rd_load(22); cont(1'b1, 4'hF);
        desel();
        oe_n = 1'b0;
        cont(1'b1, 4'hF); desel(); desel();
        rd_load(22); cont(1'b1, 4'hF); cont(1'b1, 4'hF);
        oe_n = 1'b1; cont(1'b1, 4'hF);
        oe_n = 1'b0; desel(); desel();

        // R7: write aborts then a real beat shows the address moved on
        cur_req = "R7";
        wr_load(24, 4'hF); cont(1'b0, 4'hF); cont(1'b0, 4'h0); cont(1'b0, 4'hF);
        desel(); desel();
        rd_load(24); for (int k = 0; k < 3; k++) cont(1'b1, 4'hF);
        desel(); desel();

        // R4/R13: walking single-lane masks; read continuation ignores we_n
        cur_req = "R13";
        wr_load(32, 4'b1110); cont(1'b1, 4'b1101); cont(1'b0, 4'b1011); cont(1'b1, 4'b0111);
        desel(); desel();
        rd_load(32); for (int k = 0; k < 3; k++) cont(1'b0, 4'h0);
        desel(); desel();
        cur_req = "R4";
        wr_load(33, 4'b1010); desel(); desel(); rd_load(33); desel(); desel();

        // R11/R12: alternate writes and reads of the same word
        cur_req = "R12";
        for (int k = 0; k < 6; k++) begin
            wr_load(40 + k, (k % 2) ? 4'b0101 : 4'h0);
            rd_load(40 + k);
        end
        desel(); desel();
        cur_req = "R11";
        wr_load(50, 4'b0011); wr_load(51, 4'h0); rd_load(50); wr_load(50, 4'h0); rd_load(51);
        desel(); desel();

        // R8: wait states inside read and write bursts
        cur_req = "R8";
        rd_load(8); cont(1'b1, 4'hF);
        cen_n = 1'b1; tick(); tick();
        cen_n = 1'b0; cont(1'b1, 4'hF);
        cen_n = 1'b1; tick();
        cen_n = 1'b0; cont(1'b1, 4'hF);
        wr_load(12, 4'h0);
        cen_n = 1'b1; tick(); tick();
        cen_n = 1'b0; cont(1'b0, 4'h0); desel();
        cen_n = 1'b1; tick();
        cen_n = 1'b0; desel(); desel();
        rd_load(12); cont(1'b1, 4'hF); desel(); desel();

        // R9: sleep blanks the bus and freezes the pipeline
        cur_req = "R9";
        rd_load(16); cont(1'b1, 4'hF);
        sleep = 1'b1; tick(); tick();
        chk(dq_oe === 1'b0, "R9", {31'b0, dq_oe}, 32'h0);
        sleep = 1'b0; cont(1'b1, 4'hF); desel(); desel();

        // R10: output enable acts without a clock edge
        rd_load(5); desel();
        oe_n = 1'b1; #1;
        chk(dq_oe === 1'b0, "R10", {31'b0, dq_oe}, 32'h0);
        oe_n = 1'b0; #1;
        chk(dq_oe === 1'b1, "R10", {31'b0, dq_oe}, 32'h1);
        chk(dq_o === mem_m[5], "R10", dq_o, mem_m[5]);
        desel(); desel();

        // R1: reset in the middle of a burst
        cur_req = "R1";
        rd_load(3); cont(1'b1, 4'hF);
        rst = 1'b1; tick(); rst = 1'b0;
        chk(dq_oe === 1'b0, "R1", {31'b0, dq_oe}, 32'h0);
        desel();

        // Random mix of all controls
        cur_req = "R5";
        for (int k = 0; k < 600; k++) begin
            cen_n = ($urandom % 8) == 0;
            sleep = ($urandom % 16) == 0;
            oe_n  = ($urandom % 4) == 0;
            cmd(($urandom % 5) == 0, $urandom % 2, $urandom % 2,
                (($urandom % 3) == 0) ? 4'($urandom) : 4'h0, int'($urandom % 64));
        end
        cen_n = 1'b0; sleep = 1'b0; oe_n = 1'b0;
        desel(); desel();

        summary();
        $finish;
    end

endmodule